// File: doc/BRIEF.md
# Serial Stereo Audio Input Receiver

The receiver takes a three-wire serial audio stream and turns it into parallel signed samples for a downstream interpolation filter. The three wires are a bit clock, a word-select clock and a data line. All three lines are sampled asynchronously in the system clock domain. Data bits are taken on bit clock rising edges. On every word-select transition, the most recent 16 bits become a sample. The sample goes to channel 1 if word select was high during the half-period that just ended, and to channel 2 if it was low.

Each channel has its own output word and a one-cycle valid strobe. An active-low hold input clears both output words to zero and suppresses the strobes. System software holds it low for at least one word-select period after the serial clocks start running.

Top module: `stereo_serial_rx`

## Requirements
- R1: Serial data is sent most significant bit first and is sampled on each rising edge of `sclk_in`. Bit 15 of an output word is the first of the 16 bits that were kept.
- R2: On each transition of `wsel_in`, the last 16 bits received are transferred to an output word.
- R3: A falling transition of `wsel_in` (the high half ended) loads `ch1_word`. A rising transition (the low half ended) loads `ch2_word`.
- R4: If more than 16 bits arrive in one half-period, the earliest ones are discarded and only the final 16 are kept.
- R5: Each captured word raises that channel's valid output for exactly one system clock cycle. There is one strobe per `wsel_in` transition, and the two strobes are never high together.
- R6: While `hold_n` is low, both output words read zero and no valid strobe is issued, even if `wsel_in` transitions.
- R7: An output word keeps its value until the next capture for that channel. Bit clock activity without a `wsel_in` transition changes neither word.
- R8: After reset, both words are zero and both strobes are low.
- R9: Samples keep their two's complement bit pattern exactly, including 0x8000, 0x7FFF and 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hold_n | input | 1 | Active-low hold; clears words and suppresses strobes |
| sclk_in | input | 1 | Serial bit clock, asynchronous |
| wsel_in | input | 1 | Word-select clock: high = channel 1, low = channel 2 |
| sdin | input | 1 | Serial data, MSB first |
| ch1_word | output | 16 | Latest channel-1 sample |
| ch1_valid | output | 1 | One-cycle strobe on a new channel-1 sample |
| ch2_word | output | 16 | Latest channel-2 sample |
| ch2_valid | output | 1 | One-cycle strobe on a new channel-2 sample |

## Verification
The single-cycle strobe and exclusivity properties assume that `wsel_in` transitions are several system clocks apart, and that `sclk_in` and `sdin` hold each level for at least three system clocks, so that the synchronizers never merge or miss edges. The hold properties assume that a change of `hold_n` reaches the outputs within three system clocks. The stimulus keeps within these limits. It runs the bit clock at one eighth of the system clock, changes data and word select only while the bit clock is low, and waits at least twelve system clocks after the final word-select transition of each scenario before it inspects the outputs.

// File: rtl/ssrx_pkg.sv
`timescale 1ns/1ps
package ssrx_pkg;
  localparam int unsigned SAMPLE_W    = 16;
  localparam int unsigned SYNC_STAGES = 2;
  // positions inside the synchronized input vector
  localparam int unsigned IX_SCLK = 0;
  localparam int unsigned IX_WSEL = 1;
  localparam int unsigned IX_DATA = 2;
  localparam int unsigned IX_HOLD = 3;
  localparam int unsigned N_SYNC  = 4;
  // word-select level of the half-period that just ended
  typedef enum logic {SIDE_CH2 = 1'b0, SIDE_CH1 = 1'b1} side_e;
endpackage

// File: rtl/ssrx_sync.sv
`timescale 1ns/1ps
module ssrx_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_async;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ssrx_edge.sv
`timescale 1ns/1ps
module ssrx_edge #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] chg,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign chg      = lvl ^ prev_q;
  assign lvl_prev = prev_q;
endmodule

// File: rtl/ssrx_shift.sv
`timescale 1ns/1ps
module ssrx_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  logic [W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/ssrx_route.sv
`timescale 1ns/1ps
module ssrx_route
  import ssrx_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         cap_en,
  input  side_e        cap_side,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] ch1_word,
  output logic         ch1_valid,
  output logic [W-1:0] ch2_word,
  output logic         ch2_valid
);
  // slot index equals the side_e encoding: 1 = channel 1, 0 = channel 2
  logic [W-1:0] slot_q [2];
  logic [1:0]   strobe_q;

  for (genvar c = 0; c < 2; c++) begin : g_slot
    logic [W-1:0] slot_d;
    logic         strobe_d;
    logic         hit;

    assign hit = run && cap_en && (cap_side == side_e'(c));

    always_comb begin
      slot_d   = slot_q[c];
      strobe_d = 1'b0;
      if (!run) begin
        slot_d = '0;
      end else if (hit) begin
        slot_d   = word_in;
        strobe_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[c]   <= '0;
        strobe_q[c] <= 1'b0;
      end else begin
        slot_q[c]   <= slot_d;
        strobe_q[c] <= strobe_d;
      end
    end
  end

  assign ch1_word  = slot_q[SIDE_CH1];
  assign ch1_valid = strobe_q[SIDE_CH1];
  assign ch2_word  = slot_q[SIDE_CH2];
  assign ch2_valid = strobe_q[SIDE_CH2];
endmodule

// File: rtl/stereo_serial_rx.sv
`timescale 1ns/1ps
module stereo_serial_rx
  import ssrx_pkg::*;
#(
  parameter int unsigned WORD_W     = SAMPLE_W,
  parameter int unsigned SYNC_DEPTH = SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_n,
  input  logic              sclk_in,
  input  logic              wsel_in,
  input  logic              sdin,
  output logic [WORD_W-1:0] ch1_word,
  output logic              ch1_valid,
  output logic [WORD_W-1:0] ch2_word,
  output logic              ch2_valid
);
  logic [N_SYNC-1:0] raw_vec, sync_vec;
  logic [1:0]        clk_chg, clk_prev;
  logic              sclk_rise;
  logic              wsel_edge;
  side_e             ended_side;
  logic [WORD_W-1:0] shift_word;

  always_comb begin
    raw_vec          = '0;
    raw_vec[IX_SCLK] = sclk_in;
    raw_vec[IX_WSEL] = wsel_in;
    raw_vec[IX_DATA] = sdin;
    raw_vec[IX_HOLD] = hold_n;
  end

  ssrx_sync #(.W(N_SYNC), .STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_vec),
    .q       (sync_vec)
  );

  ssrx_edge #(.W(2)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      ({sync_vec[IX_WSEL], sync_vec[IX_SCLK]}),
    .chg      (clk_chg),
    .lvl_prev (clk_prev)
  );

  assign sclk_rise  = clk_chg[0] && !clk_prev[0];
  assign wsel_edge  = clk_chg[1];
  assign ended_side = side_e'(clk_prev[1]);

  ssrx_shift #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sclk_rise),
    .bit_in   (sync_vec[IX_DATA]),
    .word     (shift_word)
  );

  ssrx_route #(.W(WORD_W)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (sync_vec[IX_HOLD]),
    .cap_en    (wsel_edge),
    .cap_side  (ended_side),
    .word_in   (shift_word),
    .ch1_word  (ch1_word),
    .ch1_valid (ch1_valid),
    .ch2_word  (ch2_word),
    .ch2_valid (ch2_valid)
  );
endmodule

// File: rtl/ssrx_checker.sv
`timescale 1ns/1ps
module ssrx_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         hold_n,
  input logic [W-1:0] ch1_word,
  input logic         ch1_valid,
  input logic [W-1:0] ch2_word,
  input logic         ch2_valid
);
  logic [2:0] hold_hist;
  logic [1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_hist <= '0;
      low_cnt   <= '0;
    end else begin
      hold_hist <= {hold_hist[1:0], !hold_n};
      if (hold_n)              low_cnt <= '0;
      else if (low_cnt != 2'd3) low_cnt <= low_cnt + 2'd1;
    end
  end

  a_r5_ch1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_valid |=> !ch1_valid);
  a_r5_ch2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ch2_valid |=> !ch2_valid);
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch1_valid && ch2_valid));
  a_r6_quiet_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (low_cnt == 2'd3) |-> (!ch1_valid && !ch2_valid && ch1_word == '0 && ch2_word == '0));
  a_r7_ch1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch1_word) |-> (ch1_valid || (|hold_hist)));
  a_r7_ch2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch2_word) |-> (ch2_valid || (|hold_hist)));
endmodule

bind stereo_serial_rx ssrx_checker #(.W(WORD_W)) u_ssrx_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .hold_n    (hold_n),
  .ch1_word  (ch1_word),
  .ch1_valid (ch1_valid),
  .ch2_word  (ch2_word),
  .ch2_valid (ch2_valid)
);

// File: tb/test_stereo_serial_rx.sv
`timescale 1ns/1ps
module test_stereo_serial_rx;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n, hold_n, sclk_in, wsel_in, sdin;
  logic [15:0] ch1_word, ch2_word;
  logic        ch1_valid, ch2_valid;

  int n_chk = 0, n_fail = 0;
  int cnt1 = 0, cnt2 = 0, viol = 0;
  logic [15:0] last1 = '0, last2 = '0;
  logic v1_prev = 1'b0, v2_prev = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stereo_serial_rx i_stereo_serial_rx (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .sclk_in(sclk_in),
    .wsel_in(wsel_in), .sdin(sdin), .ch1_word(ch1_word), .ch1_valid(ch1_valid),
    .ch2_word(ch2_word), .ch2_valid(ch2_valid)
  );

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (ch1_valid) begin cnt1++; last1 = ch1_word; end
      if (ch2_valid) begin cnt2++; last2 = ch2_word; end
      if (ch1_valid && ch2_valid) viol++;
      if ((ch1_valid && v1_prev) || (ch2_valid && v2_prev)) viol++;
      v1_prev = ch1_valid;
      v2_prev = ch2_valid;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick_bit(logic b);
    sdin    = b;
    sclk_in = 1'b0;
    repeat (HALF) @(negedge clk);
    sclk_in = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk_in = 1'b0;
  endtask

  task automatic send_half(logic lvl, logic [15:0] v, int extra);
    wsel_in = lvl;
    for (int i = 0; i < extra; i++) tick_bit(i[0]);
    for (int i = 15; i >= 0; i--) tick_bit(v[i]);
  endtask

  task automatic send_frame(logic [15:0] a, logic [15:0] b, int extra);
    send_half(1'b1, a, extra);
    send_half(1'b0, b, extra);
    wsel_in = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic expect_frame(string req, logic [15:0] a, logic [15:0] b, int extra);
    int c1 = cnt1, c2 = cnt2;
    send_frame(a, b, extra);
    check(req, "ch1 strobe count", cnt1 - c1, 1);
    check(req, "ch2 strobe count", cnt2 - c2, 1);
    check(req, "ch1 captured", last1, a);
    check(req, "ch2 captured", last2, b);
    check(req, "ch1_word port", ch1_word, a);
    check(req, "ch2_word port", ch2_word, b);
  endtask

  task automatic t_reset();
    check("R8", "ch1_word after reset", ch1_word, 0);
    check("R8", "ch2_word after reset", ch2_word, 0);
    check("R8", "ch1_valid after reset", ch1_valid, 0);
    check("R8", "ch2_valid after reset", ch2_valid, 0);
  endtask

  task automatic t_hold_startup();
    send_frame(16'h1111, 16'h2222, 0);
    check("R6", "no ch1 strobe in hold", cnt1, 0);
    check("R6", "no ch2 strobe in hold", cnt2, 0);
    check("R6", "ch1_word zero in hold", ch1_word, 0);
    check("R6", "ch2_word zero in hold", ch2_word, 0);
    hold_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_basic();
    expect_frame("R1 R2 R3", 16'h1234, 16'hA5C3, 0);
  endtask

  task automatic t_extra_bits();
    expect_frame("R4", 16'h0F0F, 16'hF0F0, 5);
  endtask

  task automatic t_signed();
    expect_frame("R9", 16'h8000, 16'h7FFF, 0);
    expect_frame("R9", 16'hFFFF, 16'h0001, 0);
  endtask

  task automatic t_hold_words();
    int c1, c2;
    expect_frame("R7", 16'hAAAA, 16'h5555, 0);
    c1 = cnt1; c2 = cnt2;
    send_half(1'b1, 16'hFFFF, 3);   // bit clock activity, no word-select edge
    repeat (12) @(negedge clk);
    check("R7", "ch1_word unchanged", ch1_word, 16'hAAAA);
    check("R7", "ch2_word unchanged", ch2_word, 16'h5555);
    check("R7", "no strobes without edge", (cnt1 - c1) + (cnt2 - c2), 0);
  endtask

  task automatic t_strobes();
    check("R5", "strobe width/overlap violations", viol, 0);
  endtask

  task automatic t_hold_midstream();
    int c1, c2;
    hold_n = 1'b0;
    repeat (8) @(negedge clk);
    check("R6", "ch1_word cleared by hold", ch1_word, 0);
    check("R6", "ch2_word cleared by hold", ch2_word, 0);
    c1 = cnt1; c2 = cnt2;
    send_frame(16'h3C3C, 16'hC3C3, 0);
    check("R6", "no strobes during hold", (cnt1 - c1) + (cnt2 - c2), 0);
    check("R6", "ch1_word still zero", ch1_word, 0);
    hold_n = 1'b1;
    repeat (8) @(negedge clk);
    expect_frame("R6 R3", 16'h0042, 16'hBEEF, 0);
  endtask

  initial begin
    rst_n = 1'b0; hold_n = 1'b0; sclk_in = 1'b0; wsel_in = 1'b1; sdin = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    t_reset();
    t_hold_startup();
    t_basic();
    t_extra_bits();
    t_signed();
    t_hold_words();
    t_hold_midstream();
    t_strobes();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule